// File: doc/BRIEF.md
# Masked Data Breakpoint Channel

This block implements one hardware watchpoint for a processor's data port. Software programs two words through a small write port. The first is an address word. The second is a control word, which carries a load-enable bit, a store-enable bit and a short mask field. The block compares every data access on the access bus with the programmed address, ignoring the address bits that the mask releases. When the address matches and the access direction is enabled, it raises a one-cycle break pulse. The pulse is registered from the access, so the core can stall or squash the access before the access commits.

The mask field covers only the low address bits. Every bit above the field is forced to one, and the result is always reduced to a contiguous mask. As a result the watched window is always a power-of-two sized, naturally aligned block of bytes: it starts at `address & mask` and spans `~mask + 1` bytes. The normalised mask is also driven out, so the debug logic can report the window that is actually watched.

The comparator keeps a snapshot of its programming. A write reloads that snapshot only when the write changes something that matters. A new address is taken when the channel is armed and the value differs. The control word is re-evaluated when its enable or mask bits change.

Top module: `dbk_unit`

## Requirements
- R1: After reset, `brk_o` is 0, the channel is disarmed and `eff_mask_o` is 32'hFFFF_FFC0 (the mask field resets to zero).
- R2: Bits [31:6] of `eff_mask_o` are always 1. Only the control mask field in bits [5:0] can clear mask bits. A field bit of 1 compares that address bit, and a field bit of 0 ignores it.
- R3: When the widened mask is contiguous, that is when `((~m + 1) & ~m) == 0`, `eff_mask_o` equals the widened mask. For example, field 6'b111000 gives 32'hFFFF_FFF8.
- R4: A non-contiguous widened mask is cut back to its run of ones counted down from bit 31, and every lower bit is cleared. For example, field 6'b101111 gives 32'hFFFF_FFE0 and field 6'b010101 gives 32'hFFFF_FFC0.
- R5: Control bit 30 arms breaks on reads (`acc_rd`) and control bit 31 arms breaks on writes (`acc_wr`). With both bits clear, no break is ever signalled.
- R6: An enabled access breaks exactly when `(acc_addr & eff_mask_o) == (address_word & eff_mask_o)`. This is the aligned window of `~eff_mask_o + 1` bytes.
- R7: `brk_o` is high for the single cycle after a valid enabled matching access, and never at any other time. A register write in the same cycle as an access does not affect that access.
- R8: A control write that changes only bits outside [31:30] and [5:0] leaves matching unchanged. An address written while the channel is disarmed takes effect as soon as the channel is armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the address word, 1 selects the control word |
| wr_data | input | 32 | Write data |
| acc_valid | input | 1 | Data access present this cycle |
| acc_addr | input | 32 | Data access byte address |
| acc_rd | input | 1 | Access is a load |
| acc_wr | input | 1 | Access is a store |
| brk_o | output | 1 | One-cycle break pulse for the previous cycle's access |
| eff_mask_o | output | 32 | Normalised mask currently programmed |

## Verification
The assertions rely on reset being held long enough for the write and access inputs to be low on the first sampled edge, and on `wr_sel` being meaningful only while `wr_en` is high. The bench drives every input at the falling clock edge, so the inputs are stable across each rising edge. It keeps all strobes low during reset. After reset it mixes directed sequences with random ones. The random accesses use addresses close to the programmed word, so that both matches and misses occur under every mask shape.

// File: rtl/dbk_pkg.sv
package dbk_pkg;
  // Snapshot of the comparator programming held between register writes.
  typedef struct packed {
    logic ld;
    logic st;
  } dbk_en_t;

  localparam int DBK_AW_DEF  = 32;
  localparam int DBK_FW_DEF  = 6;
  localparam int DBK_LD_DEF  = 30;
  localparam int DBK_ST_DEF  = 31;
endpackage

// File: rtl/dbk_mask_norm.sv
module dbk_mask_norm #(
  parameter int AW = 32,
  parameter int FW = 6
) (
  input  logic [FW-1:0] field_i,
  output logic [AW-1:0] mask_o,
  output logic          contig_o
);
  localparam int HI_W = AW - FW;

  // Force every bit above the field to one.
  function automatic logic [AW-1:0] widen(input logic [FW-1:0] f);
    return {{HI_W{1'b1}}, f};
  endfunction

  // Keep the leading run of ones from the MSB and clear everything below.
  function automatic logic [AW-1:0] lead_run(input logic [AW-1:0] m);
    logic [AW-1:0] r;
    logic          run;
    run = 1'b1;
    for (int i = AW - 1; i >= 0; i--) begin
      run  = run & m[i];
      r[i] = run;
    end
    return r;
  endfunction

  logic [AW-1:0] wide;
  logic [AW-1:0] inv;

  always_comb begin
    wide     = widen(field_i);
    inv      = ~wide;
    contig_o = ((inv + 1'b1) & inv) == '0;
    mask_o   = contig_o ? wide : lead_run(wide);
  end
endmodule

// File: rtl/dbk_regs.sv
module dbk_regs #(
  parameter int AW = 32,
  parameter int FW = 6,
  parameter int LD_BIT = 30,
  parameter int ST_BIT = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [AW-1:0] wr_data,
  output logic [AW-1:0] addr_q,
  output logic [AW-1:0] ctrl_q,
  output logic          rearm_addr,
  output logic          reeval_ctrl
);
  localparam logic [AW-1:0] EN_BITS   = (AW'(1) << LD_BIT) | (AW'(1) << ST_BIT);
  localparam logic [AW-1:0] FLD_BITS  = AW'((1 << FW) - 1);
  localparam logic [AW-1:0] LIVE_BITS = EN_BITS | FLD_BITS;

  logic armed_now;
  assign armed_now   = ctrl_q[LD_BIT] | ctrl_q[ST_BIT];
  assign rearm_addr  = wr_en && !wr_sel && armed_now && (wr_data != addr_q);
  assign reeval_ctrl = wr_en && wr_sel && (((wr_data ^ ctrl_q) & LIVE_BITS) != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      ctrl_q <= '0;
    end else if (wr_en) begin
      if (wr_sel) ctrl_q <= wr_data;
      else        addr_q <= wr_data;
    end
  end

  // R8: a write selects exactly one register; the other keeps its value
  a_r8_addr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> $stable(addr_q));
endmodule

// File: rtl/dbk_cmp.sv
module dbk_cmp
  import dbk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reeval_ctrl,
  input  logic          rearm_addr,
  input  dbk_en_t       new_en,
  input  logic [AW-1:0] new_mask,
  input  logic [AW-1:0] cur_addr,
  input  logic [AW-1:0] wr_data,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_rd,
  input  logic          acc_wr,
  output dbk_en_t       arm_q,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] mask_q,
  output logic          brk_q
);
  logic dir_hit;
  logic addr_hit;

  assign dir_hit  = (acc_rd & arm_q.ld) | (acc_wr & arm_q.st);
  assign addr_hit = (acc_addr & mask_q) == base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q  <= '0;
      base_q <= '0;
      mask_q <= '1;
      brk_q  <= 1'b0;
    end else begin
      brk_q <= acc_valid & dir_hit & addr_hit;
      if (reeval_ctrl) begin
        arm_q <= new_en;
        if (new_en.ld | new_en.st) begin
          base_q <= cur_addr & new_mask;
          mask_q <= new_mask;
        end
      end else if (rearm_addr) begin
        base_q <= wr_data & mask_q;
      end
    end
  end

  // R5: a disarmed comparator never produces a break
  a_r5_disarmed_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm_q.ld && !arm_q.st) |=> !brk_q);
  // R7: a break comes only from a valid access one cycle earlier
  a_r7_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
    brk_q |-> $past(acc_valid && (acc_rd || acc_wr)));
  // R6: a break implies the previous access lay in the watched window
  a_r6_window_hit: assert property (@(posedge clk) disable iff (!rst_n)
    brk_q |-> $past(((acc_addr ^ base_q) & mask_q) == '0));
endmodule

// File: rtl/dbk_unit.sv
module dbk_unit
  import dbk_pkg::*;
#(
  parameter int AW     = DBK_AW_DEF,
  parameter int FW     = DBK_FW_DEF,
  parameter int LD_BIT = DBK_LD_DEF,
  parameter int ST_BIT = DBK_ST_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_rd,
  input  logic          acc_wr,
  output logic          brk_o,
  output logic [AW-1:0] eff_mask_o
);
  localparam int HI_W = AW - FW;

  logic [AW-1:0] addr_q, ctrl_q;
  logic          rearm_addr, reeval_ctrl;
  logic [AW-1:0] new_mask;
  logic          cur_contig, new_contig;
  dbk_en_t       new_en, arm_q;
  logic [AW-1:0] base_q, mask_q;

  dbk_regs #(.AW(AW), .FW(FW), .LD_BIT(LD_BIT), .ST_BIT(ST_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .addr_q(addr_q), .ctrl_q(ctrl_q),
    .rearm_addr(rearm_addr), .reeval_ctrl(reeval_ctrl)
  );

  // Mask as programmed now (output) and as carried by a pending control write
  dbk_mask_norm #(.AW(AW), .FW(FW)) u_norm_cur (
    .field_i(ctrl_q[FW-1:0]), .mask_o(eff_mask_o), .contig_o(cur_contig)
  );
  dbk_mask_norm #(.AW(AW), .FW(FW)) u_norm_new (
    .field_i(wr_data[FW-1:0]), .mask_o(new_mask), .contig_o(new_contig)
  );

  assign new_en.ld = wr_data[LD_BIT];
  assign new_en.st = wr_data[ST_BIT];

  dbk_cmp #(.AW(AW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .reeval_ctrl(reeval_ctrl), .rearm_addr(rearm_addr),
    .new_en(new_en), .new_mask(new_mask), .cur_addr(addr_q), .wr_data(wr_data),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .arm_q(arm_q), .base_q(base_q), .mask_q(mask_q), .brk_q(brk_o)
  );

  // R2: bits above the field are ones
  a_r2_upper_ones: assert property (@(posedge clk) disable iff (!rst_n)
    eff_mask_o[AW-1:FW] == {HI_W{1'b1}});
  // R4: the driven mask is always one run of ones from the MSB
  a_r4_mask_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (((~eff_mask_o + 1'b1) & ~eff_mask_o) == '0));
  // R8: a control write touching no live bit leaves the comparator alone
  a_r8_ctrl_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && !reeval_ctrl) |=> $stable({arm_q, base_q, mask_q}));
  // R1: the first cycle out of reset is quiet
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !brk_o);

  logic unused_ok;
  assign unused_ok = new_contig ^ cur_contig;
endmodule

// File: tb/sim_dbk_unit.sv
module sim_dbk_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        acc_valid = 1'b0, acc_rd = 1'b0, acc_wr = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        brk_o;
  logic [31:0] eff_mask_o;

  int checks = 0;
  int errors = 0;
  string cur_req = "R6";
  bit done = 0;

  // Reference state
  logic [31:0] ref_addr = '0, ref_ctrl = '0;
  logic        exp_brk = 1'b0;

  always #2.5 clk = ~clk;

  dbk_unit u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .brk_o(brk_o), .eff_mask_o(eff_mask_o)
  );

  // Expected mask: count ones from bit 31 down until the first zero
  function automatic logic [31:0] ref_mask(input logic [31:0] ctrl);
    logic [31:0] w;
    int lead;
    w = 32'hFFFF_FFC0 | (ctrl & 32'h3F);
    lead = 0;
    while (lead < 32 && w[31 - lead]) lead++;
    if (lead == 32) return 32'hFFFF_FFFF;
    return ~(32'hFFFF_FFFF >> lead);
  endfunction

  function automatic bit field_contig(input logic [5:0] f);
    int k;
    k = 5;
    while (k >= 0 && f[k]) k--;
    while (k >= 0 && !f[k]) k--;
    return k < 0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference model, advanced on every rising edge
  always @(posedge clk) begin
    logic [31:0] m;
    if (!rst_n) begin
      ref_addr = '0; ref_ctrl = '0; exp_brk = 1'b0;
    end else begin
      m = ref_mask(ref_ctrl);
      exp_brk = acc_valid && ((acc_rd && ref_ctrl[30]) || (acc_wr && ref_ctrl[31]))
                && ((acc_addr & m) == (ref_addr & m));
      if (wr_en) begin
        if (wr_sel) ref_ctrl = wr_data;
        else        ref_addr = wr_data;
      end
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, {31'b0, brk_o}, {31'b0, exp_brk});
      check(field_contig(ref_ctrl[5:0]) ? "R3" : "R4", eff_mask_o, ref_mask(ref_ctrl));
    end
  end

  task automatic idle();
    @(negedge clk);
    wr_en = 0; acc_valid = 0; acc_rd = 0; acc_wr = 0;
  endtask

  task automatic wreg(input bit sel, input logic [31:0] v);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = v; acc_valid = 0;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic acc(input logic [31:0] a, input bit rd, input bit wr);
    @(negedge clk);
    wr_en = 0; acc_valid = 1; acc_addr = a; acc_rd = rd; acc_wr = wr;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", {31'b0, brk_o}, 32'd0);
    check("R1", eff_mask_o, 32'hFFFF_FFC0);

    // R3: contiguous field, loads only
    cur_req = "R5";
    wreg(0, 32'h1000_0010);
    wreg(1, 32'h4000_0038);
    check("R3", eff_mask_o, 32'hFFFF_FFF8);
    acc(32'h1000_0014, 1, 0);
    acc(32'h1000_0014, 0, 1);
    acc(32'h1000_0018, 1, 0);
    cur_req = "R7";
    acc(32'h1000_0017, 1, 0);
    acc(32'h1000_0017, 1, 0);
    idle(); idle();

    // R4: non-contiguous masks, stores only
    cur_req = "R6";
    wreg(1, 32'h8000_002F);
    check("R4", eff_mask_o, 32'hFFFF_FFE0);
    acc(32'h1000_001F, 0, 1);
    acc(32'h1000_0020, 0, 1);
    wreg(1, 32'hC000_0015);
    check("R4", eff_mask_o, 32'hFFFF_FFC0);
    check("R2", {6'b0, eff_mask_o[31:6]}, 32'h03FF_FFFF);
    acc(32'h1000_003C, 1, 0);
    acc(32'h1000_0040, 1, 1);
    idle();

    // R8: ignored control bits, address written while disarmed
    cur_req = "R8";
    wreg(1, 32'hC000_0415);
    acc(32'h1000_0000, 0, 1);
    wreg(1, 32'h0000_0000);
    wreg(0, 32'h2000_0100);
    acc(32'h2000_0100, 1, 1);
    wreg(1, 32'h4000_003F);
    acc(32'h2000_0100, 1, 0);
    acc(32'h2000_0101, 1, 0);
    // R7: write in the same cycle as an access
    cur_req = "R7";
    @(negedge clk);
    acc_valid = 1; acc_addr = 32'h2000_0100; acc_rd = 1; acc_wr = 0;
    wr_en = 1; wr_sel = 1; wr_data = 32'h0;
    idle(); idle();

    // Random traffic
    cur_req = "R6";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      wr_en = ($urandom_range(0, 7) == 0);
      wr_sel = $urandom_range(0, 1);
      wr_data = wr_sel ? {$urandom_range(0, 3) == 0 ? 2'b00 : 2'($urandom), 24'($urandom), 6'($urandom)}
                       : 32'h3000_0000 | 32'($urandom_range(0, 255));
      acc_valid = $urandom_range(0, 1);
      acc_addr = 32'h3000_0000 | 32'($urandom_range(0, 255));
      acc_rd = $urandom_range(0, 1);
      acc_wr = $urandom_range(0, 1);
    end
    idle(); idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule